// File: doc/BRIEF.md
# Function-Unit Operand Collection Stage

This block is the front end of one function unit in a transport-driven datapath. Transport operations each deliver one value to one operand slot, together with a two-bit mode. The unit fires only when every slot holds a valid operand and the downstream result buffer has room. On firing, a placeholder core adds all operands together (modulo 2^DW). One cycle later the sum appears on the result port as a one-cycle write pulse.

Two mechanisms let a single transport cover many executions. A sticky operand stays valid after each firing, so a constant can be loaded once and reused. A bypass-enabled slot takes its value from a fixed neighbour's result port instead of from transports. That connection stays set until it is cancelled, and a ready signal tells the neighbour when the slot can take a new value. Settings are cancelled explicitly by the clear mode, or as a side effect of a later write.

Top module: `fu_operand_stage`

## Requirements
- R1: During reset and after it, every slot is empty with no setting, `res_valid` is 0 and `chain_ready` is 0.
- R2: The unit fires in a cycle where every slot is valid and `obuf_full` is 0. In the next cycle `res_valid` is 1 and `res_data` is the sum of the operands (modulo 2^DW) as held in the firing cycle.
- R3: While any slot is empty, the unit does not fire, `res_valid` stays 0 and the held operands are kept.
- R4: While `obuf_full` is 1, the unit does not fire and all operands are kept. Firing resumes once the buffer is no longer full.
- R5: Mode 2'b00 (normal) loads `xfer_data` into slot `xfer_slot` as a valid operand. A normal operand is consumed (becomes empty) when the unit fires.
- R6: Mode 2'b01 (sticky) loads the value and marks it sticky. A sticky operand stays valid with the same value across any number of firings.
- R7: Mode 2'b10 (bypass) empties the slot and links it to the chain port. `chain_ready` is 1 when the linked slot is empty or fires in the current cycle, and is not being written by a transport. A cycle with `chain_valid` and `chain_ready` both 1 loads `chain_data` as a consumable operand.
- R8: At most one slot is linked to the chain port. Enabling bypass on one slot cancels the link on any other slot.
- R9: Mode 2'b11 (clear) empties the slot and cancels its sticky and bypass settings.
- R10: A normal or sticky write to a slot cancels that slot's previous bypass or sticky setting.
- R11: A transport written in a firing cycle takes precedence on its slot. The firing uses the old value, and the new value is kept for the next firing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised inside |
| xfer_valid | input | 1 | A transport operation targets this unit this cycle |
| xfer_slot | input | SW | Operand slot index of the transport |
| xfer_mode | input | 2 | 00 normal, 01 sticky, 10 bypass enable, 11 clear |
| xfer_data | input | DW | Operand value of the transport |
| chain_valid | input | 1 | Neighbour unit presents a result |
| chain_data | input | DW | Neighbour unit's result value |
| chain_ready | output | 1 | Linked slot takes the neighbour's value this cycle |
| obuf_full | input | 1 | Output buffer cannot take a result |
| res_valid | output | 1 | One-cycle write pulse into the output buffer |
| res_data | output | DW | Computed result |

## Verification
The bench builds the stage with three operand slots and an 8-bit data width. Three slots let the chain link move between slots other than the current target. They also let a sticky, a bypass and a normal operand coexist in one firing. The narrow width makes the sum wrap around often, so modulo behaviour is covered by both directed sums and random stimulus.

// File: rtl/fu_opstage_pkg.sv
package fu_opstage_pkg;

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'b00,
    MODE_STICKY = 2'b01,
    MODE_BYPASS = 2'b10,
    MODE_CLEAR  = 2'b11
  } opmode_e;

endpackage

// File: rtl/fu_opstage_slot.sv
module fu_opstage_slot
  import fu_opstage_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  opmode_e       mode_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          drop_byp_i,
  input  logic          fire_i,
  input  logic          chain_valid_i,
  input  logic [DW-1:0] chain_data_i,
  output logic          valid_o,
  output logic [DW-1:0] data_o,
  output logic          sticky_o,
  output logic          byp_o,
  output logic          free_o
);

  logic          valid_q, valid_n;
  logic          sticky_q, sticky_n;
  logic          byp_q, byp_n;
  logic [DW-1:0] data_q, data_n;
  logic          data_en;

  // slot can take the neighbour's value this cycle
  assign free_o = byp_q && (!valid_q || fire_i) && !wr_i;

  always_comb begin
    valid_n  = valid_q;
    sticky_n = sticky_q;
    byp_n    = byp_q;
    data_n   = data_q;
    data_en  = 1'b0;
    if (wr_i) begin
      unique case (mode_i)
        MODE_NORMAL: begin
          valid_n = 1'b1; sticky_n = 1'b0; byp_n = 1'b0;
          data_n  = wdata_i; data_en = 1'b1;
        end
        MODE_STICKY: begin
          valid_n = 1'b1; sticky_n = 1'b1; byp_n = 1'b0;
          data_n  = wdata_i; data_en = 1'b1;
        end
        MODE_BYPASS: begin
          valid_n = 1'b0; sticky_n = 1'b0; byp_n = 1'b1;
        end
        default: begin
          valid_n = 1'b0; sticky_n = 1'b0; byp_n = 1'b0;
        end
      endcase
    end else begin
      if (drop_byp_i) byp_n = 1'b0;
      if (fire_i && !sticky_q) valid_n = 1'b0;
      if (free_o && chain_valid_i) begin
        valid_n = 1'b1;
        data_n  = chain_data_i;
        data_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q  <= 1'b0;
      sticky_q <= 1'b0;
      byp_q    <= 1'b0;
    end else begin
      valid_q  <= valid_n;
      sticky_q <= sticky_n;
      byp_q    <= byp_n;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
    end else if (data_en) begin
      data_q <= data_n;
    end
  end

  assign valid_o  = valid_q;
  assign data_o   = data_q;
  assign sticky_o = sticky_q;
  assign byp_o    = byp_q;

  // R6: a sticky operand survives a firing unchanged
  a_r6_sticky_holds: assert property (@(posedge clk) disable iff (!rst_ni)
    (fire_i && sticky_q && !wr_i) |=> (valid_q && $stable(data_q)));

  // R9: explicit clear drops value and settings
  a_r9_clear_all: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_i && mode_i == MODE_CLEAR) |=> (!valid_q && !sticky_q && !byp_q));

  // R7: an accepted neighbour value lands in the slot
  a_r7_chain_capture: assert property (@(posedge clk) disable iff (!rst_ni)
    (free_o && chain_valid_i) |=> (valid_q && data_q == $past(chain_data_i)));

  // R5: a normal operand is consumed by a firing
  a_r5_consumed: assert property (@(posedge clk) disable iff (!rst_ni)
    (fire_i && !sticky_q && !wr_i && !(free_o && chain_valid_i)) |=> !valid_q);

endmodule

// File: rtl/fu_opstage_fire.sv
module fu_opstage_fire #(
  parameter int DW   = 32,
  parameter int NOPS = 2
) (
  input  logic               clk,
  input  logic               rst_ni,
  input  logic [NOPS-1:0]    valid_i,
  input  logic [NOPS*DW-1:0] data_i,
  input  logic               obuf_full_i,
  output logic               fire_o,
  output logic               res_valid_o,
  output logic [DW-1:0]      res_data_o
);

  logic [DW-1:0] sum;
  logic          res_valid_q;
  logic [DW-1:0] res_data_q;

  assign fire_o = (&valid_i) && !obuf_full_i;

  always_comb begin
    sum = '0;
    for (int i = 0; i < NOPS; i++) begin
      sum = sum + data_i[i*DW +: DW];
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_q <= 1'b0;
    end else begin
      res_valid_q <= fire_o;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      res_data_q <= '0;
    end else if (fire_o) begin
      res_data_q <= sum;
    end
  end

  assign res_valid_o = res_valid_q;
  assign res_data_o  = res_data_q;

endmodule

// File: rtl/fu_operand_stage.sv
module fu_operand_stage
  import fu_opstage_pkg::*;
#(
  parameter int DW   = 32,
  parameter int NOPS = 2,
  localparam int SW  = (NOPS > 1) ? $clog2(NOPS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          xfer_valid,
  input  logic [SW-1:0] xfer_slot,
  input  logic [1:0]    xfer_mode,
  input  logic [DW-1:0] xfer_data,
  input  logic          chain_valid,
  input  logic [DW-1:0] chain_data,
  output logic          chain_ready,
  input  logic          obuf_full,
  output logic          res_valid,
  output logic [DW-1:0] res_data
);

  logic [1:0]         rst_sync_q;
  logic               rst_int_n;
  logic [NOPS-1:0]    wr_vec, drop_vec, valid_vec, sticky_vec, byp_vec, free_vec;
  logic [NOPS*DW-1:0] data_flat;
  logic               fire;
  opmode_e            mode;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign mode = opmode_e'(xfer_mode);

  generate
    for (genvar g = 0; g < NOPS; g++) begin : g_slot
      assign wr_vec[g]   = xfer_valid && (xfer_slot == SW'(g));
      assign drop_vec[g] = xfer_valid && (mode == MODE_BYPASS) && !wr_vec[g];

      fu_opstage_slot #(.DW(DW)) u_slot (
        .clk           (clk),
        .rst_ni        (rst_int_n),
        .wr_i          (wr_vec[g]),
        .mode_i        (mode),
        .wdata_i       (xfer_data),
        .drop_byp_i    (drop_vec[g]),
        .fire_i        (fire),
        .chain_valid_i (chain_valid),
        .chain_data_i  (chain_data),
        .valid_o       (valid_vec[g]),
        .data_o        (data_flat[g*DW +: DW]),
        .sticky_o      (sticky_vec[g]),
        .byp_o         (byp_vec[g]),
        .free_o        (free_vec[g])
      );
    end
  endgenerate

  assign chain_ready = |free_vec;

  fu_opstage_fire #(.DW(DW), .NOPS(NOPS)) u_fire (
    .clk         (clk),
    .rst_ni      (rst_int_n),
    .valid_i     (valid_vec),
    .data_i      (data_flat),
    .obuf_full_i (obuf_full),
    .fire_o      (fire),
    .res_valid_o (res_valid),
    .res_data_o  (res_data)
  );

  // R8: the chain link has a single destination
  a_r8_single_dest: assert property (@(posedge clk) disable iff (!rst_int_n)
    $onehot0(byp_vec));

  // R2: a result needs every operand in the previous cycle
  a_r2_all_present: assert property (@(posedge clk) disable iff (!rst_int_n)
    res_valid |-> $past(&valid_vec));

  // R4: a full output buffer blocks the next result
  a_r4_full_blocks: assert property (@(posedge clk) disable iff (!rst_int_n)
    obuf_full |=> !res_valid);

  // R6: sticky and bypass settings are exclusive on one slot
  a_r6_sticky_not_byp: assert property (@(posedge clk) disable iff (!rst_int_n)
    (sticky_vec & byp_vec) == '0);

endmodule

// File: tb/fu_operand_stage_tb.sv
`timescale 1ns/1ps
module fu_operand_stage_tb;

  localparam int DW   = 8;
  localparam int NOPS = 3;
  localparam int SW   = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          xfer_valid;
  logic [SW-1:0] xfer_slot;
  logic [1:0]    xfer_mode;
  logic [DW-1:0] xfer_data;
  logic          chain_valid;
  logic [DW-1:0] chain_data;
  logic          chain_ready;
  logic          obuf_full;
  logic          res_valid;
  logic [DW-1:0] res_data;

  int total = 0;
  int bad   = 0;

  // bench model of the slots
  logic          m_v [NOPS];
  logic          m_s [NOPS];
  logic          m_b [NOPS];
  logic [DW-1:0] m_d [NOPS];

  always #10 clk = ~clk;

  fu_operand_stage #(.DW(DW), .NOPS(NOPS)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .xfer_valid(xfer_valid), .xfer_slot(xfer_slot), .xfer_mode(xfer_mode),
    .xfer_data(xfer_data), .chain_valid(chain_valid), .chain_data(chain_data),
    .chain_ready(chain_ready), .obuf_full(obuf_full),
    .res_valid(res_valid), .res_data(res_data)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic all_valid();
    logic a = 1'b1;
    for (int i = 0; i < NOPS; i++) a &= m_v[i];
    return a;
  endfunction

  function automatic logic [DW-1:0] op_sum();
    logic [DW-1:0] s = '0;
    for (int i = 0; i < NOPS; i++) s += m_d[i];
    return s;
  endfunction

  // one cycle: drive, check chain_ready, clock, check result, advance model
  task automatic step(input logic xv, input int xs, input logic [1:0] xm,
                      input logic [DW-1:0] xd, input logic cv,
                      input logic [DW-1:0] cd, input logic full, input string tag);
    logic fire, exp_cr;
    logic [DW-1:0] s;
    string t;
    @(negedge clk);
    xfer_valid = xv; xfer_slot = SW'(xs); xfer_mode = xm; xfer_data = xd;
    chain_valid = cv; chain_data = cd; obuf_full = full;
    #2;
    fire = all_valid() && !full;
    s = op_sum();
    exp_cr = 1'b0;
    for (int i = 0; i < NOPS; i++)
      if (m_b[i] && (!m_v[i] || fire) && !(xv && xs == i)) exp_cr = 1'b1;
    t = (tag == "") ? "R7" : tag;
    chk(chain_ready == exp_cr, t, chain_ready, exp_cr);
    @(posedge clk);
    #2;
    if (tag == "") t = fire ? "R2" : ((all_valid() && full) ? "R4" : "R3");
    else t = tag;
    chk(res_valid == fire, t, res_valid, fire);
    if (fire) chk(res_data == s, t, res_data, s);
    for (int i = 0; i < NOPS; i++) begin
      if (xv && xs == i) begin
        case (xm)
          2'b00: begin m_v[i] = 1; m_s[i] = 0; m_b[i] = 0; m_d[i] = xd; end
          2'b01: begin m_v[i] = 1; m_s[i] = 1; m_b[i] = 0; m_d[i] = xd; end
          2'b10: begin m_v[i] = 0; m_s[i] = 0; m_b[i] = 1; end
          default: begin m_v[i] = 0; m_s[i] = 0; m_b[i] = 0; end
        endcase
      end else begin
        logic cap;
        cap = m_b[i] && cv && (!m_v[i] || fire);
        if (xv && xm == 2'b10) m_b[i] = 0;
        if (fire && !m_s[i]) m_v[i] = 0;
        if (cap) begin m_v[i] = 1; m_d[i] = cd; end
      end
    end
  endtask

  task automatic idle(input string tag);
    step(0, 0, 2'b00, '0, 0, '0, 0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int unsigned seed_init;
    seed_init = $urandom(32'd2024);
    for (int i = 0; i < NOPS; i++) begin
      m_v[i] = 0; m_s[i] = 0; m_b[i] = 0; m_d[i] = '0;
    end
    rst_n = 1'b0;
    xfer_valid = 0; xfer_slot = '0; xfer_mode = 2'b00; xfer_data = '0;
    chain_valid = 0; chain_data = '0; obuf_full = 0;
    repeat (3) @(negedge clk);
    // R1: outputs quiet in reset
    chk(res_valid == 1'b0, "R1", res_valid, 0);
    chk(chain_ready == 1'b0, "R1", chain_ready, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(res_valid == 1'b0, "R1", res_valid, 0);
    chk(chain_ready == 1'b0, "R1", chain_ready, 0);
    idle("R1");

    // R3 / R2 / R5: collect three normal operands, fire once, consume
    step(1, 0, 2'b00, 8'd10, 0, '0, 0, "R3");
    step(1, 1, 2'b00, 8'd20, 0, '0, 0, "R3");
    step(1, 2, 2'b00, 8'd30, 0, '0, 0, "R3");
    idle("R2");
    idle("R5");
    idle("R5");

    // R6: two sticky operands reused, with wraparound sums
    step(1, 0, 2'b01, 8'd200, 0, '0, 0, "R6");
    step(1, 1, 2'b01, 8'd100, 0, '0, 0, "R6");
    step(1, 2, 2'b00, 8'd5, 0, '0, 0, "R6");
    idle("R6");
    step(1, 2, 2'b00, 8'd7, 0, '0, 0, "R6");
    idle("R6");

    // R4: full buffer holds back, then releases
    step(1, 2, 2'b00, 8'd1, 0, '0, 0, "R4");
    step(0, 0, 2'b00, '0, 0, '0, 1, "R4");
    step(0, 0, 2'b00, '0, 0, '0, 1, "R4");
    idle("R4");

    // R7: slot 2 linked to the chain port, repeated firing without transports
    step(1, 2, 2'b10, 8'hAA, 0, '0, 0, "R7");
    for (int k = 0; k < 5; k++) step(0, 0, 2'b00, '0, 1, 8'(k * 37 + 3), 0, "R7");
    step(0, 0, 2'b00, '0, 1, 8'd9, 1, "R7");
    step(0, 0, 2'b00, '0, 1, 8'd11, 0, "R7");

    // R8: link moves to slot 1, slot 2 becomes normal only
    step(1, 1, 2'b10, '0, 1, 8'd4, 0, "R8");
    step(1, 2, 2'b00, 8'd6, 1, 8'd50, 0, "R8");
    step(0, 0, 2'b00, '0, 1, 8'd60, 0, "R8");
    step(0, 0, 2'b00, '0, 1, 8'd70, 0, "R8");

    // R9: clearing the sticky slot stops firing
    step(1, 0, 2'b11, '0, 0, '0, 0, "R9");
    step(1, 2, 2'b00, 8'd2, 1, 8'd3, 0, "R9");
    idle("R9");
    step(1, 0, 2'b00, 8'd1, 0, '0, 0, "R9");
    idle("R9");

    // R10: a normal write on the linked slot drops the link
    step(1, 1, 2'b00, 8'd8, 1, 8'd99, 0, "R10");
    step(0, 0, 2'b00, '0, 1, 8'd99, 0, "R10");
    step(1, 0, 2'b01, 8'd40, 0, '0, 0, "R10");
    step(1, 2, 2'b00, 8'd1, 0, '0, 0, "R10");
    idle("R10");
    step(1, 0, 2'b00, 8'd3, 0, '0, 0, "R10");
    step(1, 1, 2'b00, 8'd4, 0, '0, 0, "R10");
    step(1, 2, 2'b00, 8'd5, 0, '0, 0, "R10");
    idle("R10");
    idle("R10");

    // R11: write during a firing cycle
    step(1, 0, 2'b01, 8'd100, 0, '0, 0, "R11");
    step(1, 1, 2'b01, 8'd10, 0, '0, 0, "R11");
    step(1, 2, 2'b01, 8'd1, 0, '0, 0, "R11");
    step(1, 0, 2'b00, 8'd50, 0, '0, 0, "R11");
    idle("R11");
    idle("R11");

    // random phase
    for (int n = 0; n < 1500; n++) begin
      logic xv, cv, full;
      int xs;
      logic [1:0] xm;
      xv   = ($urandom % 3) != 0;
      xs   = $urandom % NOPS;
      xm   = 2'($urandom % 4);
      cv   = $urandom % 2;
      full = ($urandom % 4) == 0;
      step(xv, xs, xm, 8'($urandom), cv, 8'($urandom), full, "");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule